// File: doc/BRIEF.md
# Cascaded Two-Stage Line-Delay Memory

This block holds two sequential-access line memories joined in series. The first memory (stage A) has its own write port: words are stored at a free-running write address on the write clock. Its read port runs on a separate read clock. On every enabled read edge, the word leaving stage A is presented at the stage A output. The same word is also stored into the second memory (stage B). In the same edge, stage B presents the word it received one line earlier. With a line of `DEPTH` words, the two outputs carry video-style data delayed by one line and by two lines.

Stage B has no control inputs of its own. Its write and read address counters move only when the stage A read enable and read reset say so. Every counter wraps without limit, and there are no full or empty flags. The user keeps the read side behind the write side. When the read side is idle, each output lowers a drive flag; this flag stands in for a high-impedance output.

Top module: `cascade_line_delay`

## Requirements
- R1: When `a_we_n` is 0 on a rising `wr_clk` edge (and `a_wres_n` is 1), `a_din` is stored into stage A at the current write address and the write address advances by one.
- R2: When `a_we_n` is 1 on a rising `wr_clk` edge, nothing is stored and the stage A write address keeps its value.
- R3: When `a_wres_n` is 0 on a rising `wr_clk` edge, the stage A write address becomes 0 and nothing is stored on that edge, whatever `a_we_n` is.
- R4: When `rd_en_n` is 0 and `rd_res_n` is 1 on a rising `rd_clk` edge, then after that edge `a_dout` holds the stage A word at the read address and `a_drive` is 1. The stage A read address then advances.
- R5: On that same edge, stage B outputs on `b_dout` (with `b_drive` 1) the word at its own address, stores the stage A word at the same address, and advances both of its counters. As a result, `b_dout` repeats the `a_dout` value of exactly `DEPTH` enabled reads before.
- R6: When `rd_en_n` is 1 (and `rd_res_n` is 1) on a rising `rd_clk` edge, `a_drive` and `b_drive` are 0 after the edge. `a_dout` and `b_dout` keep their values, no read counter and no stage B write counter moves, and nothing is stored into stage B.
- R7: When `rd_res_n` is 0 on a rising `rd_clk` edge, the stage A read address and both stage B addresses become 0. No transfer takes place and both drive flags are 0 after the edge.
- R8: Every address counter wraps from `DEPTH-1` to 0.
- R9: `wr_rst_n` and `rd_rst_n` are asynchronous active-low resets for their own clock domains. Asserting `rd_rst_n` clears both drive flags at once. Release is synchronized by two flops in the domain's own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| a_we_n | input | 1 | Active-low write enable of stage A |
| a_wres_n | input | 1 | Active-low synchronous write address reset of stage A |
| a_din | input | WIDTH | Write data into stage A |
| rd_clk | input | 1 | Read-side clock, shared by both stages |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en_n | input | 1 | Active-low read/transfer enable for both stages |
| rd_res_n | input | 1 | Active-low synchronous reset of the stage A read and stage B counters |
| a_dout | output | WIDTH | Registered stage A output (one-line delay) |
| a_drive | output | 1 | Stage A output is driven (low means high impedance) |
| b_dout | output | WIDTH | Registered stage B output (two-line delay) |
| b_drive | output | 1 | Stage B output is driven (low means high impedance) |

## Verification
Five line patterns are passed through in turn: an up ramp, a down ramp, a constant, a coarse step, and a two-value alternation. Each line is written and then read back, so the run crosses the address wrap several times. The ramps expose address order and off-by-one faults, while the constant line isolates the cascade timing from addressing. Because stage B must reproduce the previous pattern, a line that is stuck or delayed by the wrong amount shows up as a wrong value. Gapped writes and gapped reads show whether the counters and the stage B store really stop. A partial read followed by a read reset separates stage B addressing from its contents. A write reset issued together with an enabled write shows which of the two has priority.

// File: rtl/ld_pkg.sv
package ld_pkg;

  // Counter command shared by every address counter in the block.
  typedef enum logic [1:0] {
    CTR_HOLD  = 2'd0,
    CTR_STEP  = 2'd1,
    CTR_CLEAR = 2'd2
  } ctr_op_e;

  // Active-low reset wins over active-low enable.
  function automatic ctr_op_e ctr_decode(input logic res_n, input logic en_n);
    if (!res_n)     return CTR_CLEAR;
    else if (!en_n) return CTR_STEP;
    else            return CTR_HOLD;
  endfunction

endpackage

// File: rtl/ld_rst_sync.sv
module ld_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/ld_addr_ctr.sv
module ld_addr_ctr
  import ld_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctr_op_e       op,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nxt;

  always_comb begin
    addr_nxt = addr_q;
    case (op)
      CTR_CLEAR: addr_nxt = '0;
      CTR_STEP:  addr_nxt = (addr_q == LAST) ? '0 : addr_q + 1'b1;
      default:   addr_nxt = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_nxt;
  end

  assign addr = addr_q;

  assert_ctr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_STEP && addr == LAST) |=> (addr == '0));

  assert_ctr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_HOLD) |=> $stable(addr));

  assert_ctr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_CLEAR) |=> (addr == '0));

  assert_ctr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_STEP && addr != LAST) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/ld_line_mem.sv
module ld_line_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Storage array: written on the clock, read asynchronously so that a
  // read and a write of one address on one edge return the old word.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cascade_line_delay.sv
module cascade_line_delay
  import ld_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             a_we_n,
  input  logic             a_wres_n,
  input  logic [WIDTH-1:0] a_din,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_en_n,
  input  logic             rd_res_n,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_drive,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_drive
);

  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic wr_srst_n;
  logic rd_srst_n;

  ld_rst_sync i_wr_sync (.clk(wr_clk), .arst_n(wr_rst_n), .srst_n(wr_srst_n));
  ld_rst_sync i_rd_sync (.clk(rd_clk), .arst_n(rd_rst_n), .srst_n(rd_srst_n));

  // Counter commands for each clock domain.
  ctr_op_e wr_op;
  ctr_op_e rd_op;
  logic    a_store;
  logic    xfer;

  assign wr_op   = ctr_decode(a_wres_n, a_we_n);
  assign rd_op   = ctr_decode(rd_res_n, rd_en_n);
  assign a_store = (wr_op == CTR_STEP);
  assign xfer    = (rd_op == CTR_STEP);

  // Address counters: one for the stage A write side, and one each for
  // the stage A read, stage B write and stage B read sides.
  logic [AW-1:0] a_waddr;
  logic [AW-1:0] a_raddr;
  logic [AW-1:0] b_waddr;
  logic [AW-1:0] b_raddr;

  ld_addr_ctr #(.DEPTH(DEPTH)) i_a_wctr (
    .clk(wr_clk), .rst_n(wr_srst_n), .op(wr_op), .addr(a_waddr));

  ld_addr_ctr #(.DEPTH(DEPTH)) i_a_rctr (
    .clk(rd_clk), .rst_n(rd_srst_n), .op(rd_op), .addr(a_raddr));

  ld_addr_ctr #(.DEPTH(DEPTH)) i_b_wctr (
    .clk(rd_clk), .rst_n(rd_srst_n), .op(rd_op), .addr(b_waddr));

  ld_addr_ctr #(.DEPTH(DEPTH)) i_b_rctr (
    .clk(rd_clk), .rst_n(rd_srst_n), .op(rd_op), .addr(b_raddr));

  // Stage memories.
  logic [WIDTH-1:0] a_word;
  logic [WIDTH-1:0] b_word;

  ld_line_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_mem_a (
    .clk(wr_clk), .wr_en(a_store), .wr_addr(a_waddr), .wr_data(a_din),
    .rd_addr(a_raddr), .rd_data(a_word));

  ld_line_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_mem_b (
    .clk(rd_clk), .wr_en(xfer), .wr_addr(b_waddr), .wr_data(a_word),
    .rd_addr(b_raddr), .rd_data(b_word));

  // Output registers: next state.
  logic [WIDTH-1:0] a_q, a_q_nxt;
  logic [WIDTH-1:0] b_q, b_q_nxt;
  logic             drv_q, drv_nxt;

  always_comb begin
    a_q_nxt = a_q;
    b_q_nxt = b_q;
    drv_nxt = xfer;
    if (xfer) begin
      a_q_nxt = a_word;
      b_q_nxt = b_word;
    end
  end

  // Output registers: state.
  always_ff @(posedge rd_clk or negedge rd_srst_n) begin
    if (!rd_srst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      drv_q <= 1'b0;
    end else begin
      a_q   <= a_q_nxt;
      b_q   <= b_q_nxt;
      drv_q <= drv_nxt;
    end
  end

  assign a_dout  = a_q;
  assign b_dout  = b_q;
  assign a_drive = drv_q;
  assign b_drive = drv_q;

  // Checks on the read-side control behaviour.
  assert_read_drives_R4: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    (!rd_en_n && rd_res_n) |=> (a_drive && b_drive));

  assert_idle_float_R6: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    (rd_en_n && rd_res_n) |=> (!a_drive && !b_drive && $stable(a_dout) && $stable(b_dout)));

  assert_rres_clear_R7: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    (!rd_res_n) |=> (!a_drive && !b_drive && a_raddr == '0 && b_waddr == '0));

  assert_b_aligned_R5: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    (b_waddr == b_raddr));

endmodule

// File: tb/test_cascade_line_delay.sv
module test_cascade_line_delay;

  localparam int W    = 8;
  localparam int D    = 16;
  localparam int NPAT = 5;
  // Each entry: {seed, step}; word i of a line = seed + i*step.
  localparam logic [15:0] PATS [NPAT] = '{16'h0001, 16'hFFFF, 16'h5A00, 16'h0F11, 16'h5580};
  localparam logic [15:0] GAPL = 16'h3003;
  localparam logic [15:0] QL   = 16'hC005;

  logic         wr_clk = 1'b0, rd_clk = 1'b0;
  logic         wr_rst_n, rd_rst_n, a_we_n, a_wres_n, rd_en_n, rd_res_n;
  logic [W-1:0] a_din, a_dout, b_dout;
  logic         a_drive, b_drive;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #5 wr_clk = ~wr_clk;
  initial begin #2; forever #5 rd_clk = ~rd_clk; end

  cascade_line_delay #(.WIDTH(W), .DEPTH(D)) i_cascade_line_delay (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .a_we_n(a_we_n), .a_wres_n(a_wres_n),
    .a_din(a_din), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n),
    .rd_res_n(rd_res_n), .a_dout(a_dout), .a_drive(a_drive),
    .b_dout(b_dout), .b_drive(b_drive));

  function automatic logic [7:0] pat(input logic [15:0] e, input int i);
    return e[15:8] + 8'(i) * e[7:0];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_step(input logic we_n, input logic wres_n, input logic [7:0] d);
    a_we_n = we_n; a_wres_n = wres_n; a_din = d;
    @(negedge wr_clk);
    a_we_n = 1'b1; a_wres_n = 1'b1;
  endtask

  task automatic rd_step(input logic en_n, input logic res_n);
    rd_en_n = en_n; rd_res_n = res_n;
    @(negedge rd_clk);
    rd_en_n = 1'b1; rd_res_n = 1'b1;
  endtask

  task automatic write_line(input logic [15:0] e);
    for (int i = 0; i < D; i++) wr_step(1'b0, 1'b1, pat(e, i));
  endtask

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    a_we_n = 1'b1; a_wres_n = 1'b1; a_din = '0;
    rd_en_n = 1'b1; rd_res_n = 1'b1;
    repeat (3) @(negedge rd_clk);
    chk("R9 reset a_drive", {7'b0, a_drive}, 8'h00);
    chk("R9 reset b_drive", {7'b0, b_drive}, 8'h00);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);

    // Table walk: each line written then read; stage B repeats the previous line.
    for (int p = 0; p < NPAT; p++) begin
      write_line(PATS[p]);
      @(negedge rd_clk);
      for (int i = 0; i < D; i++) begin
        rd_step(1'b0, 1'b1);
        chk("R1 R4 R8 a_dout", a_dout, pat(PATS[p], i));
        chk("R4 a_drive", {7'b0, a_drive}, 8'h01);
        if (p > 0) begin
          chk("R5 b_dout", b_dout, pat(PATS[p-1], i));
          chk("R5 b_drive", {7'b0, b_drive}, 8'h01);
        end
      end
    end

    // Gapped writes (R2) and gapped reads (R6).
    @(negedge wr_clk);
    for (int i = 0; i < D; i++) begin
      wr_step(1'b0, 1'b1, pat(GAPL, i));
      wr_step(1'b1, 1'b1, 8'hEE);
    end
    @(negedge rd_clk);
    for (int i = 0; i < D; i++) begin
      rd_step(1'b0, 1'b1);
      chk("R2 a_dout after gapped write", a_dout, pat(GAPL, i));
      chk("R6 b_dout after gapped read", b_dout, pat(PATS[NPAT-1], i));
      rd_step(1'b1, 1'b1);
      chk("R6 a_drive idle", {7'b0, a_drive}, 8'h00);
      chk("R6 b_drive idle", {7'b0, b_drive}, 8'h00);
      chk("R6 a_dout held", a_dout, pat(GAPL, i));
    end

    // Write reset with write enable (R3), then partial read and read reset (R7).
    @(negedge wr_clk);
    for (int i = 0; i < 5; i++) wr_step(1'b0, 1'b1, 8'h77);
    wr_step(1'b0, 1'b0, 8'h99);
    write_line(QL);
    @(negedge rd_clk);
    for (int i = 0; i < 3; i++) begin
      rd_step(1'b0, 1'b1);
      chk("R3 a_dout after write reset", a_dout, pat(QL, i));
      chk("R5 b_dout partial", b_dout, pat(GAPL, i));
    end
    rd_step(1'b0, 1'b0);
    chk("R7 a_drive in read reset", {7'b0, a_drive}, 8'h00);
    chk("R7 b_drive in read reset", {7'b0, b_drive}, 8'h00);
    for (int i = 0; i < D; i++) begin
      rd_step(1'b0, 1'b1);
      chk("R7 a_dout restart", a_dout, pat(QL, i));
      chk("R7 b_dout restart", b_dout, (i < 3) ? pat(QL, i) : pat(GAPL, i));
    end

    // Asynchronous read-domain reset (R9).
    rd_step(1'b0, 1'b1);
    chk("R9 drive before reset", {7'b0, a_drive}, 8'h01);
    #1 rd_rst_n = 1'b0;
    #1;
    chk("R9 async a_drive", {7'b0, a_drive}, 8'h00);
    chk("R9 async b_drive", {7'b0, b_drive}, 8'h00);
    chk("R9 async a_dout", a_dout, 8'h00);
    rd_rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge rd_clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule